// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a synchronous, single-clock requester use an external asynchronous static RAM. The RAM is 16 bits wide, split into two byte lanes. It has active-low chip enable, write enable and output enable pins, and one active-low strobe for each byte lane. The requester offers one access at a time over a valid/ready handshake. Each access carries a read/write flag, a word address, 16 bits of write data and an active-high two-bit lane mask. Read data returns in a register, marked by a one-cycle valid pulse.

The controller builds every memory cycle from whole clock cycles. Four parameters give the minimum number of cycles for:
- read access,
- write pulse,
- data setup before the end of the write,
- bus turnaround after a read.

The address pins change only on the edge that ends a cycle in which every strobe was inactive. A write happens only while chip enable, write enable and the selected lane strobes are low together, and output enable is held high throughout the write. The controller drives the data pins itself only inside the write pulse, never in its first cycle, and releases them on the same edge that write enable rises. A request whose lane mask is empty finishes without touching the memory pins.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, chip enable, write enable, output enable and both lane strobes are high. Both data-drive enables are low, `rd_valid` is low and `req_ready` is high.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. After a request with a non-empty mask is taken, `req_ready` stays low until that access and its recovery cycles have ended.
- R3: `mem_addr` is loaded only when a request with a non-empty mask is taken. It changes only on an edge that ends a cycle in which chip enable, write enable and both lane strobes were all high.
- R4: A read holds chip enable and output enable low and write enable high for RD_CYC cycles. Mask bit 0 selects `mem_dq_in[7:0]` and drives `mem_lb_n` low; mask bit 1 selects `mem_dq_in[15:8]` and drives `mem_ub_n` low. The data pins are captured on the edge that ends the last read cycle, and unselected lanes return zero.
- R5: A write holds chip enable, write enable and the selected lane strobes low for max(WP_CYC, DS_CYC+1) cycles, with output enable high throughout. Only the masked lanes of the addressed word change in the memory.
- R6: The drive enable `mem_dq_oe[i]` is high only for masked lanes, only from the second write cycle through the last one, and only while that lane's strobe is low. It falls on the same edge as write enable rises, which gives at least DS_CYC cycles of valid data before the end of the write.
- R7: Output enable and write enable are never low in the same cycle.
- R8: After a read, all strobes stay high for TA_CYC cycles (at least one) before `req_ready` rises again. After a write they stay high for one cycle.
- R9: A request with mask 2'b00 is taken without asserting any strobe, and `req_ready` stays high. If it is a read, `rd_valid` pulses in the next cycle with `rd_data` equal to zero. If it is a write, it changes no memory content.
- R10: Each read request produces exactly one one-cycle `rd_valid` pulse. For a read with a non-empty mask, the pulse falls in the cycle in which the strobes return high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask; bit 0 = low byte, bit 1 = high byte |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 16 | Registered read data |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low-byte lane strobe, active low |
| mem_ub_n | output | 1 | High-byte lane strobe, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 2 | Per-lane enable for the data drivers |
| mem_dq_in | input | 16 | Data returned by the memory pins |

## Verification
Two things happen on one clock edge at the end of every write: write enable rises and the data drivers release. At the end of every read, the read-data capture and the return of all strobes to high also share an edge. The bench provokes both with writes and reads under each of the three non-empty masks. Some of these are issued back to back, with `req_valid` held high, so that a new request waits on the recovery cycles. A behavioural per-cycle model judges every pin on every clock. A memory stub beside it stores a byte only while the chip, write and lane strobes are low with that lane driven, so data released late or early shows up in later read-backs.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RECOV = 2'd3
  } seq_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int unsigned NLANE  = 2,
  parameter int unsigned RD_CYC = 7,
  parameter int unsigned WP_CYC = 6,
  parameter int unsigned DS_CYC = 3,
  parameter int unsigned TA_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [NLANE-1:0] req_mask,
  output logic             req_ready,
  output logic             start,
  output logic             zero_rd,
  output logic             strobe_d,
  output logic             drv_d,
  output logic             capture,
  output logic             mem_ce_n,
  output logic             mem_we_n,
  output logic             mem_oe_n
);

  localparam int unsigned RD_EFF = max_u(RD_CYC, 1);
  localparam int unsigned WP_EFF = max_u(WP_CYC, DS_CYC + 1);
  localparam int unsigned TA_EFF = max_u(TA_CYC, 1);
  localparam int unsigned CMAX   = max_u(max_u(RD_EFF, WP_EFF), TA_EFF);
  localparam int unsigned CW     = $clog2(CMAX + 1);

  seq_state_e    state, nxt;
  logic [CW-1:0] cnt, cnt_d;
  logic          cnt_en;
  logic          ce_n_d, we_n_d, oe_n_d;

  assign req_ready = (state == ST_IDLE);

  always_comb begin
    nxt     = state;
    cnt_d   = cnt;
    start   = 1'b0;
    zero_rd = 1'b0;
    capture = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          if (|req_mask) begin
            start = 1'b1;
            if (req_write) begin
              nxt   = ST_WRITE;
              cnt_d = CW'(WP_EFF - 1);
            end else begin
              nxt   = ST_READ;
              cnt_d = CW'(RD_EFF - 1);
            end
          end else begin
            zero_rd = !req_write;
          end
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          capture = 1'b1;
          nxt     = ST_RECOV;
          cnt_d   = CW'(TA_EFF - 1);
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
      ST_WRITE: begin
        if (cnt == '0) begin
          nxt   = ST_RECOV;
          cnt_d = '0;
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt == '0) nxt = ST_IDLE;
        else           cnt_d = cnt - 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign cnt_en   = (state != ST_IDLE) || start;
  assign strobe_d = (nxt == ST_READ) || (nxt == ST_WRITE);
  assign drv_d    = (state == ST_WRITE) && (nxt == ST_WRITE);
  assign ce_n_d   = !strobe_d;
  assign we_n_d   = (nxt != ST_WRITE);
  assign oe_n_d   = (nxt != ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
    end else begin
      state    <= nxt;
      if (cnt_en) cnt <= cnt_d;
      mem_ce_n <= ce_n_d;
      mem_we_n <= we_n_d;
      mem_oe_n <= oe_n_d;
    end
  end

  // R7: the memory never drives while the controller writes
  p_oe_we_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R9: an empty-mask request leaves chip enable high and the port ready
  p_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_mask == '0)) |=> (mem_ce_n && req_ready));

  // R8: the port is never ready in the cycle the chip deselects
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> !req_ready);

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned NLANE  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    zero_rd,
  input  logic                    strobe_d,
  input  logic                    drv_d,
  input  logic                    capture,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [NLANE*LANE_W-1:0] req_wdata,
  input  logic [NLANE-1:0]        req_mask,
  input  logic [NLANE*LANE_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [NLANE-1:0]        mem_lane_n,
  output logic [NLANE*LANE_W-1:0] mem_dq_out,
  output logic [NLANE-1:0]        mem_dq_oe,
  output logic                    rd_valid,
  output logic [NLANE*LANE_W-1:0] rd_data
);

  localparam int unsigned DATA_W = NLANE * LANE_W;

  logic [NLANE-1:0]  mask_q, mask_src;
  logic [DATA_W-1:0] cap_data;
  logic              rd_en;

  assign mask_src = start ? req_mask : mask_q;
  assign rd_en    = capture || zero_rd;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign cap_data[l*LANE_W +: LANE_W] =
      (capture && mask_q[l]) ? mem_dq_in[l*LANE_W +: LANE_W] : '0;

    // R6: a lane is driven only while its own strobe is active
    p_oe_under_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe[l] |-> !mem_lane_n[l]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mask_q     <= '0;
      mem_lane_n <= '1;
      mem_dq_oe  <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      if (start) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
        mask_q     <= req_mask;
      end
      mem_lane_n <= strobe_d ? ~mask_src : '1;
      mem_dq_oe  <= drv_d ? mask_src : '0;
      rd_valid   <= rd_en;
      if (rd_en) rd_data <= cap_data;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned RD_CYC = 7,
  parameter int unsigned WP_CYC = 6,
  parameter int unsigned DS_CYC = 3,
  parameter int unsigned TA_CYC = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*LANE_W-1:0]   req_wdata,
  input  logic [1:0]            req_mask,
  output logic                  rd_valid,
  output logic [2*LANE_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic                  mem_lb_n,
  output logic                  mem_ub_n,
  output logic [2*LANE_W-1:0]   mem_dq_out,
  output logic [1:0]            mem_dq_oe,
  input  logic [2*LANE_W-1:0]   mem_dq_in
);

  localparam int unsigned NLANE = 2;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             start, zero_rd, strobe_d, drv_d, capture;
  logic [NLANE-1:0] lane_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sram_lane_seq #(
    .NLANE (NLANE),
    .RD_CYC(RD_CYC),
    .WP_CYC(WP_CYC),
    .DS_CYC(DS_CYC),
    .TA_CYC(TA_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_mask (req_mask),
    .req_ready(req_ready),
    .start    (start),
    .zero_rd  (zero_rd),
    .strobe_d (strobe_d),
    .drv_d    (drv_d),
    .capture  (capture),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n)
  );

  sram_lane_io #(
    .ADDR_W(ADDR_W),
    .LANE_W(LANE_W),
    .NLANE (NLANE)
  ) u_io (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .zero_rd   (zero_rd),
    .strobe_d  (strobe_d),
    .drv_d     (drv_d),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_lane_n(lane_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[1];

  // R3: address moves only out of a fully deselected cycle
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_addr != $past(mem_addr)) |->
      $past(mem_ce_n && mem_we_n && mem_lb_n && mem_ub_n));

  // R4: a lane strobe is never active without chip enable
  p_lane_needs_ce_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_lb_n && mem_ub_n) |-> !mem_ce_n);

  // R6: drivers only inside the write pulse and never in its first cycle
  p_drive_in_write_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

  localparam int RD  = 7;
  localparam int WP  = 6;
  localparam int DS  = 3;
  localparam int TA  = 3;
  localparam int WPE = (WP > DS) ? WP : DS + 1;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [18:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic [1:0]  mem_dq_oe;
  logic [15:0] mem_dq_in;

  int checks, errors, reads_issued, rvalid_seen;
  bit done;

  sram_lane_ctrl #(.RD_CYC(RD), .WP_CYC(WP), .DS_CYC(DS), .TA_CYC(TA)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lanes(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  // ---------------- memory stub ----------------
  logic [15:0] smem [logic [18:0]];
  logic [15:0] pend;
  logic [1:0]  pend_v;

  function automatic logic [15:0] stub_rd(input logic [18:0] a);
    if (smem.exists(a)) return smem[a];
    return 16'h0000;
  endfunction

  always @(negedge clk) begin
    logic [15:0] w;
    w = stub_rd(mem_addr);
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in <= {!mem_ub_n ? w[15:8] : 8'hA5, !mem_lb_n ? w[7:0] : 8'hA5};
    else
      mem_dq_in <= 16'hA5A5;
    if (!mem_ce_n && !mem_we_n) begin
      if (!mem_lb_n && mem_dq_oe[0]) begin pend[7:0]  <= mem_dq_out[7:0];  pend_v[0] <= 1'b1; end
      if (!mem_ub_n && mem_dq_oe[1]) begin pend[15:8] <= mem_dq_out[15:8]; pend_v[1] <= 1'b1; end
    end else if (|pend_v) begin
      if (pend_v[0]) w[7:0]  = pend[7:0];
      if (pend_v[1]) w[15:8] = pend[15:8];
      smem[mem_addr] = w;
      pend_v <= 2'b00;
    end
  end

  // ---------------- reference model ----------------
  int          ph, left;
  logic [18:0] m_addr;
  logic [15:0] m_wdata;
  logic [1:0]  m_mask;
  bit          e_rvalid;
  logic [15:0] e_rdata;
  logic [15:0] shadow [logic [18:0]];

  function automatic logic [15:0] sh_rd(input logic [18:0] a);
    if (shadow.exists(a)) return shadow[a];
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; left = 0; m_addr = '0; m_wdata = '0; m_mask = '0;
      e_rvalid = 0; e_rdata = '0;
    end else begin
      e_rvalid = 0;
      case (ph)
        0: if (req_valid) begin
          if (req_mask == 2'b00) begin
            if (!req_write) begin e_rvalid = 1; e_rdata = 16'h0; end
          end else begin
            m_addr = req_addr; m_wdata = req_wdata; m_mask = req_mask;
            ph = req_write ? 2 : 1;
            left = req_write ? WPE : RD;
          end
        end
        1: begin
          left--;
          if (left == 0) begin
            e_rvalid = 1; e_rdata = lanes(sh_rd(m_addr), m_mask);
            ph = 3; left = TA;
          end
        end
        2: begin
          left--;
          if (left == 0) begin
            logic [15:0] w;
            w = sh_rd(m_addr);
            if (m_mask[0]) w[7:0]  = m_wdata[7:0];
            if (m_mask[1]) w[15:8] = m_wdata[15:8];
            shadow[m_addr] = w;
            ph = 3; left = 1;
          end
        end
        default: begin
          left--;
          if (left == 0) ph = 0;
        end
      endcase
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit act;
      logic [1:0] e_lane, e_oe;
      act    = (ph == 1) || (ph == 2);
      e_lane = act ? ~m_mask : 2'b11;
      e_oe   = (ph == 2 && left < WPE) ? m_mask : 2'b00;
      chk(req_ready == (ph == 0), "R2 R8 req_ready", req_ready, ph == 0);
      chk(mem_ce_n == !act, "R4 R5 mem_ce_n", mem_ce_n, !act);
      chk(mem_we_n == (ph != 2), "R5 mem_we_n", mem_we_n, ph != 2);
      chk(mem_oe_n == (ph != 1), "R4 R7 mem_oe_n", mem_oe_n, ph != 1);
      chk({mem_ub_n, mem_lb_n} == e_lane, "R4 R5 R9 lane strobes", {mem_ub_n, mem_lb_n}, e_lane);
      chk(mem_addr == m_addr, "R3 mem_addr", mem_addr, m_addr);
      chk(mem_dq_oe == e_oe, "R6 mem_dq_oe", mem_dq_oe, e_oe);
      if (|e_oe)
        chk(lanes(mem_dq_out, e_oe) == lanes(m_wdata, e_oe), "R6 mem_dq_out",
            mem_dq_out, m_wdata);
      chk(rd_valid == e_rvalid, "R10 rd_valid", rd_valid, e_rvalid);
      if (e_rvalid)
        chk(rd_data == e_rdata, "R4 R9 rd_data", rd_data, e_rdata);
      if (rd_valid) rvalid_seen++;
    end
  end

  task automatic req(input bit w, input logic [18:0] a, input logic [15:0] d,
                     input logic [1:0] m);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    if (!w) reads_issued++;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; reads_issued = 0; rvalid_seen = 0; done = 0;
    pend = '0; pend_v = '0; mem_dq_in = 16'hA5A5;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_mask = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111, "R1 strobes",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
    chk(mem_dq_oe == 2'b00, "R1 mem_dq_oe", mem_dq_oe, 2'b00);
    chk(!rd_valid && req_ready, "R1 rd_valid/req_ready", {rd_valid, req_ready}, 2'b01);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    req(1, 19'h00010, 16'h1234, 2'b11);
    req(0, 19'h00010, 16'h0000, 2'b11);
    req(1, 19'h00010, 16'hABCD, 2'b01);     // R5 low lane only
    req(1, 19'h7FFFF, 16'h5A5A, 2'b10);     // R5 high lane only
    req(0, 19'h00010, 16'h0000, 2'b10);     // R4 high lane read
    req(0, 19'h00010, 16'h0000, 2'b01);     // R4 low lane read
    req(1, 19'h00010, 16'hFFFF, 2'b00);     // R9 empty write
    req(0, 19'h00020, 16'h0000, 2'b00);     // R9 empty read
    req(0, 19'h00021, 16'h0000, 2'b00);     // R9 back to back empty read
    req(0, 19'h00010, 16'h0000, 2'b11);
    for (int i = 0; i < 8; i++)
      req(1, 19'h00100 + 19'(i), 16'h1111 * 16'(i + 1), 2'(i % 3 + 1));
    for (int i = 0; i < 8; i++)
      req(0, 19'h00100 + 19'(i), 16'h0000, 2'(3 - i % 3));
    req(0, 19'h7FFFF, 16'h0000, 2'b11);
    repeat (30) @(negedge clk);

    // memory content written through the pins
    chk(stub_rd(19'h00010) == 16'h12CD, "R5 R9 stub word 0x10", stub_rd(19'h00010), 16'h12CD);
    chk(stub_rd(19'h7FFFF) == 16'h5A00, "R5 stub word 0x7FFFF", stub_rd(19'h7FFFF), 16'h5A00);
    for (int i = 0; i < 8; i++) begin
      logic [18:0] a;
      a = 19'h00100 + 19'(i);
      chk(stub_rd(a) == sh_rd(a), "R5 R6 stub word block", stub_rd(a), sh_rd(a));
    end
    chk(rvalid_seen == reads_issued, "R10 one pulse per read", rvalid_seen, reads_issued);
    finish_run();
  end

endmodule